// File: doc/BRIEF.md
# Programmable Countdown Timer with Fractional Tick Period

The block is a down-counting timer for a chip's peripheral set. A prescaler produces ticks. Each tick lasts a whole number of clock cycles, and a 32-bit binary fraction is added to an accumulator at every tick. When that accumulator carries, the tick it belongs to is one clock longer. Each tick lowers a current-count register by one. When the count runs out, the block raises a one-clock expiry pulse. It then either refills the count from a limit register and keeps going, or switches itself off.

Software drives the block through a single command port. Each cycle carries one command: load the limit (with or without copying it into the count), load the count, load the whole or the fractional part of the tick period, start in periodic or one-shot mode, or stop. The live count and the mode are always visible on the outputs. A zero limit at refill time, or a zero whole period, takes the timer out of service instead of letting it spin.

Top module: `countdown_timer`

## Requirements
- R1: The mode output is a 2-bit code: 0 off, 1 periodic, 2 one-shot, and 3 never appears. After reset, mode, count and expiry are all zero. A command is accepted when `cmd_valid` is high. `cmd_sel` picks the command: 0 limit, 1 count, 2 whole period, 3 fraction, 4 run, 5 stop. `cmd_flag` means reload (for a limit command) or one-shot (for a run command).
- R2: While enabled, each tick lowers the count by one. A tick that finds the count at 1 expires instead: `expire_o` is high for the one cycle after that edge, and in periodic mode the count takes the limit value and ticking continues. An enabled timer whose count is 0 expires at the next edge.
- R3: A one-shot expiry leaves the mode off and the count at 0, and no later pulse follows.
- R4: An expiry refill with a zero limit turns the timer off with the count at 0. A tick taken while the whole period is zero also turns it off, and the count then freezes.
- R5: A run command while off with a zero whole period is ignored, and the mode stays off.
- R6: A run command while enabled only changes the mode. The tick phase continues unchanged.
- R7: A stop command turns the timer off and the count output keeps its value from that edge onward.
- R8: A limit command with reload copies the data into both the limit and the count, and restarts the tick phase if the timer is running. Without reload, only the limit changes. The new limit is used at the next refill.
- R9: A count command replaces the count and restarts the tick phase if the timer is running. When it lands on the edge of a due expiry, the write wins and no pulse is produced.
- R10: After a restart the first tick comes W cycles later. Each later tick lasts W cycles, plus one when adding the fraction F to the accumulator carries out of 32 bits. The accumulator is cleared on every restart.
- R11: The count never rises between ticks. It changes only by a decrement, a refill or a write, and an expiry that is due yields 0 rather than a wrapped value.
- R12: A whole-period write keeps the current count and takes effect at the next tick boundary, not in the middle of the tick already under way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_sel | input | 3 | Command code |
| cmd_flag | input | 1 | Reload flag for a limit command, one-shot flag for a run command |
| cmd_data | input | 32 | Command operand |
| count_o | output | 32 | Live count |
| mode_o | output | 2 | Current mode |
| expire_o | output | 1 | One-cycle expiry pulse |

## Verification
Two events can fall on the same edge: a command that rewrites the count (a count write, or a limit write with reload) and the tick that would expire the timer. The bench creates this collision by running a one-cycle-tick timer from a count of 3 and placing a count write on exactly the third edge. It then checks three things: no pulse appears, the written value is present, and the next expiry arrives a full seven ticks after the restart. A related collision, a run command landing partway through a tick, is judged by the expiry edge. It must match the original phase and not a restarted one.

// File: rtl/cdt_pkg.sv
package cdt_pkg;

  typedef enum logic [1:0] {
    MODE_OFF      = 2'd0,
    MODE_PERIODIC = 2'd1,
    MODE_ONESHOT  = 2'd2
  } cdt_mode_e;

  typedef enum logic [2:0] {
    CMD_LIMIT = 3'd0,
    CMD_COUNT = 3'd1,
    CMD_WHOLE = 3'd2,
    CMD_FRAC  = 3'd3,
    CMD_RUN   = 3'd4,
    CMD_STOP  = 3'd5
  } cdt_cmd_e;

endpackage

// File: rtl/cdt_prescaler.sv
module cdt_prescaler #(
  parameter int DATA_W = 32,
  parameter int FRAC_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              restart,
  input  logic              whole_we,
  input  logic              frac_we,
  input  logic [DATA_W-1:0] wdata,
  output logic              tick,
  output logic              whole_zero
);
  localparam int LEN_W = DATA_W + 1;

  logic [DATA_W-1:0] whole_q;
  logic [FRAC_W-1:0] frac_q;
  logic [FRAC_W-1:0] acc_q;
  logic [LEN_W-1:0]  phase_q;
  logic [LEN_W-1:0]  len_q;
  logic [FRAC_W:0]   acc_sum;

  // Fraction step: carry in the top bit, new accumulator below.
  function automatic logic [FRAC_W:0] frac_step(input logic [FRAC_W-1:0] acc,
                                                input logic [FRAC_W-1:0] frac);
    return {1'b0, acc} + {1'b0, frac};
  endfunction

  // Length of a tick: whole cycles plus the carry.
  function automatic logic [LEN_W-1:0] tick_len(input logic [DATA_W-1:0] whole,
                                                input logic carry);
    return LEN_W'(whole) + LEN_W'(carry);
  endfunction

  assign acc_sum    = frac_step(acc_q, frac_q);
  assign whole_zero = (whole_q == '0);
  assign tick       = run && !restart && ((phase_q + LEN_W'(1)) == len_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      whole_q <= '0;
      frac_q  <= '0;
      acc_q   <= '0;
      phase_q <= '0;
      len_q   <= '0;
    end else begin
      if (whole_we) whole_q <= wdata;
      if (frac_we)  frac_q  <= wdata[FRAC_W-1:0];
      if (restart) begin
        phase_q <= '0;
        acc_q   <= '0;
        len_q   <= tick_len(whole_q, 1'b0);
      end else if (tick) begin
        phase_q <= '0;
        acc_q   <= acc_sum[FRAC_W-1:0];
        len_q   <= tick_len(whole_q, acc_sum[FRAC_W]);
      end else if (run) begin
        phase_q <= phase_q + LEN_W'(1);
      end
    end
  end

  // R10: while running, the phase stays inside the current tick length
  assert_phase_in_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !restart) |-> (phase_q < len_q));

endmodule

// File: rtl/cdt_count_core.sv
module cdt_count_core
  import cdt_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] wdata,
  input  logic              limit_we,
  input  logic              reload_flag,
  input  logic              count_we,
  input  logic              run_req,
  input  logic              run_oneshot,
  input  logic              stop_req,
  input  logic              tick,
  input  logic              whole_zero,
  output logic              restart,
  output logic              running,
  output logic [DATA_W-1:0] count_o,
  output logic [1:0]        mode_o,
  output logic              expire_o
);

  cdt_mode_e         mode_q, n_mode, req_mode, mode_eff;
  logic [DATA_W-1:0] count_q, n_count;
  logic [DATA_W-1:0] limit_q, n_limit;
  logic              expire_q, n_exp;
  logic              due;
  logic              count_load;

  function automatic logic expiry_due(input logic [DATA_W-1:0] cnt, input logic tk);
    return (cnt == '0) || (tk && (cnt == DATA_W'(1)));
  endfunction

  // Mode after an expiry: periodic continues only with a non-zero limit.
  function automatic cdt_mode_e mode_after(input cdt_mode_e m, input logic [DATA_W-1:0] lim);
    return (m == MODE_PERIODIC && lim != '0) ? MODE_PERIODIC : MODE_OFF;
  endfunction

  function automatic logic [DATA_W-1:0] count_after(input cdt_mode_e m,
                                                    input logic [DATA_W-1:0] lim);
    return (m == MODE_PERIODIC) ? lim : '0;
  endfunction

  assign running    = (mode_q != MODE_OFF);
  assign req_mode   = run_oneshot ? MODE_ONESHOT : MODE_PERIODIC;
  assign mode_eff   = (run_req && running) ? req_mode : mode_q;
  assign due        = expiry_due(count_q, tick);
  assign count_load = count_we || (limit_we && reload_flag);

  always_comb begin
    n_mode  = mode_q;
    n_count = count_q;
    n_limit = limit_q;
    n_exp   = 1'b0;
    restart = 1'b0;
    if (limit_we) n_limit = wdata;
    if (stop_req) begin
      n_mode = MODE_OFF;
    end else if (count_load) begin
      n_count = wdata;
      if (running) begin
        restart = 1'b1;
        if (whole_zero) n_mode = MODE_OFF;
      end
    end else if (run_req && !running) begin
      if (!whole_zero) begin
        n_mode  = req_mode;
        restart = 1'b1;
      end
    end else if (running) begin
      n_mode = mode_eff;
      if (due) begin
        n_exp   = 1'b1;
        n_count = count_after(mode_eff, limit_q);
        n_mode  = mode_after(mode_eff, limit_q);
      end else if (tick) begin
        n_count = count_q - DATA_W'(1);
      end
      if (tick && whole_zero) n_mode = MODE_OFF;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= MODE_OFF;
      count_q  <= '0;
      limit_q  <= '0;
      expire_q <= 1'b0;
    end else begin
      mode_q   <= n_mode;
      count_q  <= n_count;
      limit_q  <= n_limit;
      expire_q <= n_exp;
    end
  end

  assign count_o  = count_q;
  assign mode_o   = mode_q;
  assign expire_o = expire_q;

  // R1: the unused mode code never appears
  assert_mode_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q != cdt_mode_e'(2'd3));

  // R2: a pulse only follows a cycle in which the timer was enabled
  assert_expiry_needs_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
    expire_q |-> ($past(mode_q) != MODE_OFF));

  // R3: a one-shot expiry never leaves the timer in one-shot mode
  assert_oneshot_stops_R3: assert property (@(posedge clk) disable iff (!rst_n)
    expire_q |-> (mode_q != MODE_ONESHOT));

  // R4: a tick under a zero whole period switches the timer off
  assert_zero_period_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && whole_zero) |=> (mode_q == MODE_OFF));

  // R5: a run command with no period leaves the timer off
  assert_run_rejected_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run_req && mode_q == MODE_OFF && whole_zero) |=> (mode_q == MODE_OFF));

  // R7: stop freezes the count and turns the timer off
  assert_stop_freezes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |=> (mode_q == MODE_OFF && count_q == $past(count_q)));

  // R9: a count write on an expiry edge suppresses the pulse
  assert_write_beats_expiry_R9: assert property (@(posedge clk) disable iff (!rst_n)
    count_we |=> !expire_q);

  // R11: without a write, the count never rises except on a refill
  assert_count_no_rise_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !count_load && !stop_req) |=> (count_q <= $past(count_q) || expire_q));

endmodule

// File: rtl/countdown_timer.sv
module countdown_timer
  import cdt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int FRAC_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_sel,
  input  logic              cmd_flag,
  input  logic [DATA_W-1:0] cmd_data,
  output logic [DATA_W-1:0] count_o,
  output logic [1:0]        mode_o,
  output logic              expire_o
);

  cdt_cmd_e cmd;
  logic     limit_we, count_we, whole_we, frac_we, run_req, stop_req;
  logic     tick, whole_zero, restart, running;

  assign cmd      = cdt_cmd_e'(cmd_sel);
  assign limit_we = cmd_valid && (cmd == CMD_LIMIT);
  assign count_we = cmd_valid && (cmd == CMD_COUNT);
  assign whole_we = cmd_valid && (cmd == CMD_WHOLE);
  assign frac_we  = cmd_valid && (cmd == CMD_FRAC);
  assign run_req  = cmd_valid && (cmd == CMD_RUN);
  assign stop_req = cmd_valid && (cmd == CMD_STOP);

  cdt_prescaler #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_presc (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (running),
    .restart    (restart),
    .whole_we   (whole_we),
    .frac_we    (frac_we),
    .wdata      (cmd_data),
    .tick       (tick),
    .whole_zero (whole_zero)
  );

  cdt_count_core #(.DATA_W(DATA_W)) u_core (
    .clk         (clk),
    .rst_n       (rst_n),
    .wdata       (cmd_data),
    .limit_we    (limit_we),
    .reload_flag (cmd_flag),
    .count_we    (count_we),
    .run_req     (run_req),
    .run_oneshot (cmd_flag),
    .stop_req    (stop_req),
    .tick        (tick),
    .whole_zero  (whole_zero),
    .restart     (restart),
    .running     (running),
    .count_o     (count_o),
    .mode_o      (mode_o),
    .expire_o    (expire_o)
  );

endmodule

// File: tb/sim_countdown_timer.sv
module sim_countdown_timer;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  localparam logic [2:0] S_LIMIT = 3'd0, S_COUNT = 3'd1, S_WHOLE = 3'd2,
                         S_FRAC = 3'd3, S_RUN = 3'd4, S_STOP = 3'd5;

  // {whole, fraction, limit, cycles from run to first pulse}
  localparam int NV = 5;
  localparam logic [127:0] VEC [NV] = '{
    {32'd3, 32'h0000_0000, 32'd4, 32'd12},
    {32'd1, 32'h0000_0000, 32'd5, 32'd5},
    {32'd2, 32'h8000_0000, 32'd5, 32'd12},
    {32'd5, 32'h4000_0000, 32'd3, 32'd15},
    {32'd1, 32'hC000_0000, 32'd9, 32'd15}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_sel = '0;
  logic        cmd_flag = 1'b0;
  logic [31:0] cmd_data = '0;
  logic [31:0] count_o;
  logic [1:0]  mode_o;
  logic        expire_o;

  int checks = 0;
  int errors = 0;

  countdown_timer u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_sel(cmd_sel),
    .cmd_flag(cmd_flag), .cmd_data(cmd_data), .count_o(count_o),
    .mode_o(mode_o), .expire_o(expire_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Called at a negedge; sampled at the next posedge; returns at the following negedge.
  task automatic cmd(input logic [2:0] sel, input logic flag, input logic [31:0] data);
    cmd_valid = 1'b1; cmd_sel = sel; cmd_flag = flag; cmd_data = data;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0; cmd_flag = 1'b0; cmd_data = '0;
  endtask

  task automatic idle(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic setup(input logic [31:0] w, input logic [31:0] f, input logic [31:0] l);
    cmd(S_STOP, 1'b0, '0);
    cmd(S_WHOLE, 1'b0, w);
    cmd(S_FRAC, 1'b0, f);
    cmd(S_LIMIT, 1'b1, l);
  endtask

  // Counts negedges until a pulse is seen, including the current one.
  task automatic wait_exp(input int maxn, output int n);
    n = 0;
    while (!expire_o && n < maxn) begin
      @(negedge clk);
      n++;
    end
  endtask

  // Same, but starts looking at the next negedge.
  task automatic wait_next(input int maxn, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!expire_o && n < maxn);
  endtask

  function automatic longint carries(input longint k, input longint f);
    return (k * f) >>> 32;
  endfunction

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 reset count", count_o, 0);
    check("R1 reset mode", mode_o, 0);
    check("R1 reset expire", expire_o, 0);

    // R5 run rejected with zero period
    cmd(S_RUN, 1'b0, '0);
    check("R5 run rejected mode", mode_o, 0);
    idle(5);
    check("R5 still off", mode_o, 0);

    // Vector table: R2 / R10 periodic timing with fractions
    for (int i = 0; i < NV; i++) begin
      logic [31:0] w, f, l, n1;
      longint second;
      {w, f, l, n1} = VEC[i];
      setup(w, f, l);
      cmd(S_RUN, 1'b0, '0);
      check("R1 periodic code", mode_o, 1);
      wait_exp(400, n);
      check("R10 first expiry cycle", n, n1);
      check("R2 pulse seen", expire_o, 1);
      check("R2 refill from limit", count_o, l);
      second = longint'(l) * longint'(w) + carries(2 * longint'(l) - 1, longint'(f))
               - carries(longint'(l) - 1, longint'(f));
      wait_next(400, n);
      check("R10 second expiry interval", n, second);
    end

    // R3 one-shot
    setup(2, 0, 3);
    cmd(S_RUN, 1'b1, '0);
    check("R1 one-shot code", mode_o, 2);
    wait_exp(50, n);
    check("R3 one-shot expiry cycle", n, 6);
    check("R3 mode off", mode_o, 0);
    check("R3 count zero", count_o, 0);
    wait_next(12, n);
    check("R3 no later pulse", expire_o, 0);

    // R7 stop freezes, R11 live count
    setup(4, 0, 10);
    cmd(S_RUN, 1'b0, '0);
    idle(5);
    check("R11 count after one tick", count_o, 9);
    idle(4);
    cmd(S_STOP, 1'b0, '0);
    check("R7 stop mode", mode_o, 0);
    check("R7 frozen count", count_o, 8);
    idle(20);
    check("R7 count held", count_o, 8);

    // R6 run while enabled keeps phase
    setup(4, 0, 3);
    cmd(S_RUN, 1'b0, '0);
    idle(5);
    cmd(S_RUN, 1'b1, '0);
    check("R6 mode switched", mode_o, 2);
    wait_exp(40, n);
    check("R6 expiry on original phase", n, 6);
    check("R6 one-shot then off", mode_o, 0);

    // R8 limit with reload restarts phase
    setup(4, 0, 3);
    cmd(S_RUN, 1'b0, '0);
    idle(1);
    cmd(S_LIMIT, 1'b1, 2);
    check("R8 reload copies count", count_o, 2);
    wait_exp(40, n);
    check("R8 restarted expiry", n, 8);

    // R8 limit without reload
    setup(4, 0, 3);
    cmd(S_RUN, 1'b0, '0);
    idle(1);
    cmd(S_LIMIT, 1'b0, 5);
    check("R8 count untouched", count_o, 3);
    wait_exp(40, n);
    check("R8 expiry unchanged", n, 10);
    check("R8 new limit at refill", count_o, 5);

    // R9 count write collides with expiry
    setup(1, 0, 3);
    cmd(S_RUN, 1'b0, '0);
    idle(2);
    check("R9 no early pulse", expire_o, 0);
    cmd(S_COUNT, 1'b0, 7);
    check("R9 write wins, no pulse", expire_o, 0);
    check("R9 written count", count_o, 7);
    wait_exp(40, n);
    check("R9 expiry after restart", n, 7);

    // R4 zero limit at refill
    setup(1, 0, 0);
    cmd(S_COUNT, 1'b0, 2);
    cmd(S_RUN, 1'b0, '0);
    wait_exp(20, n);
    check("R4 pulse on zero-limit refill", n, 2);
    check("R4 off after zero limit", mode_o, 0);
    check("R4 count zero", count_o, 0);

    // R4 zero period while running
    setup(3, 0, 10);
    cmd(S_RUN, 1'b0, '0);
    cmd(S_WHOLE, 1'b0, 0);
    idle(2);
    check("R4 zero period off", mode_o, 0);
    check("R4 last tick counted", count_o, 9);
    idle(10);
    check("R4 no further ticks", count_o, 9);

    // R12 period change at next boundary
    setup(4, 0, 3);
    cmd(S_RUN, 1'b0, '0);
    idle(1);
    cmd(S_WHOLE, 1'b0, 2);
    check("R12 count kept", count_o, 3);
    wait_exp(40, n);
    check("R12 expiry with new period from boundary", n, 6);

    // R2 zero count while enabled expires at once
    setup(5, 0, 4);
    cmd(S_COUNT, 1'b0, 0);
    cmd(S_RUN, 1'b0, '0);
    wait_exp(20, n);
    check("R2 immediate expiry", n, 1);
    check("R2 refilled", count_o, 4);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule